// File: doc/BRIEF.md
# Vector type configuration validator

This block takes the type word and the application vector length that come with a vector set-length request. It checks them and updates two architectural registers: the active vector type and the vector length (vl). The type word packs five fields: the register-group multiplier (LMUL), the element-width code (SEW), the tail-agnostic and mask-agnostic policy bits, and an alternate-format flag. It also carries an illegal marker in its top bit. A configuration input says whether the alternate-format extension is present, and that input changes which bits count as reserved.

On a legal request the type word is stored as given. vl is set to the smaller of the requested length and VLMAX, where VLMAX is the number of elements that fit in the selected register group. On an illegal request the stored type becomes a word with only its top bit set, and vl becomes zero. Results are registered on the clock edge that samples the request. Both registers hold their value until the next request.

Top module: `vtype_cfg_validator`

## Requirements
- R1: After synchronous active-high reset, vtype_o has only bit XLEN-1 set and vl_o is zero.
- R2: The fields of the type word are LMUL code in bits [2:0], SEW code in bits [5:3], tail-agnostic at bit 6, mask-agnostic at bit 7 and alternate-format at bit 8. A legal request stores the word unchanged in vtype_o on the clock edge at which req_valid is high.
- R3: A request whose bit XLEN-1 is set is illegal.
- R4: With altfmt_en high, any set bit in positions 9 through XLEN-2 makes the request illegal.
- R5: With altfmt_en low, bits 8 through XLEN-2 are reserved, so a set bit 8 makes the request illegal.
- R6: With altfmt_en high, a set bit 8 is legal only for SEW code 0 (8-bit) or 1 (16-bit). With any other SEW code it makes the request illegal.
- R7: The element width is 8 << SEW code. A request whose element width exceeds ELEN is illegal.
- R8: LMUL code 4 is illegal. LMUL codes 5, 6 and 7 mean 1/8, 1/4 and 1/2. Such a fractional request is illegal when the element width exceeds ELEN times that fraction.
- R9: An illegal request sets vtype_o to 1 << (XLEN-1) and vl_o to zero.
- R10: A legal request sets vl_o to min(req_avl, VLMAX). VLMAX is (VLEN / element width) << code for LMUL codes 0 to 3, and (VLEN / element width) >> (8 - code) for codes 5 to 7.
- R11: In a cycle with req_valid low, vtype_o and vl_o keep their values, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A set-length request is present this cycle |
| altfmt_en | input | 1 | The alternate-format extension is present |
| req_vtype | input | XLEN | Proposed type word |
| req_avl | input | XLEN | Requested application vector length |
| vtype_o | output | XLEN | Stored vector type register |
| vl_o | output | XLEN | Stored vector length register |

## Verification
The bench sweeps all 512 values of the low nine type bits, with the extension both off and on, and for each computes legality and VLMAX arithmetically. A design that used the wrong reserved boundary would either accept bit 8 with the extension off, or reject a valid alternate-format request. A design that did not check the element width against the alternate-format flag would accept that flag with 32-bit or 64-bit elements. Requested lengths just below, at and above VLMAX catch a wrong comparison in the minimum. Walking single bits through the reserved span and the top bit catches a mask that is one position off. Changing the inputs while req_valid is low catches a register that updates without a request.

// File: rtl/vtype_cfg_pkg.sv
package vtype_cfg_pkg;
  localparam int unsigned LMUL_LSB = 0;
  localparam int unsigned SEW_LSB  = 3;
  localparam int unsigned TA_BIT   = 6;
  localparam int unsigned MA_BIT   = 7;
  localparam int unsigned ALT_BIT  = 8;
  localparam int unsigned RSV_LSB  = 9;

  localparam logic [2:0] LMUL_RSVD = 3'd4;

  // element width in bits for a SEW code
  function automatic logic [31:0] elem_bits(input logic [2:0] code);
    return 32'd8 << code;
  endfunction

  // right shift that turns a fractional LMUL code into its divisor
  function automatic logic [3:0] frac_shift(input logic [2:0] code);
    return 4'd8 - {1'b0, code};
  endfunction
endpackage

// File: rtl/vtype_field_check.sv
module vtype_field_check
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ELEN = 64
) (
  input  logic                     top_bit,
  input  logic [XLEN-2:RSV_LSB]    rsv_bits,
  input  logic                     alt_bit,
  input  logic                     alt_enable,
  input  logic [2:0]               sew_code,
  input  logic [2:0]               lmul_code,
  output logic                     legal
);
  logic [31:0] width_bits;
  logic [31:0] frac_cap;
  logic        rsv_hit;
  logic        alt_bad;
  logic        too_wide;
  logic        lmul_bad;

  always_comb begin
    width_bits = elem_bits(sew_code);
    frac_cap   = 32'(ELEN) >> frac_shift(lmul_code);
    rsv_hit    = (|rsv_bits) | (alt_bit & ~alt_enable);
    alt_bad    = alt_bit & (sew_code > 3'd1);
    too_wide   = width_bits > 32'(ELEN);
    lmul_bad   = 1'b0;
    if (lmul_code == LMUL_RSVD) begin
      lmul_bad = 1'b1;
    end else if (lmul_code[2]) begin
      lmul_bad = width_bits > frac_cap;
    end
    legal = ~(top_bit | rsv_hit | alt_bad | too_wide | lmul_bad);
  end
endmodule

// File: rtl/vtype_vlmax_calc.sv
module vtype_vlmax_calc
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLW = $clog2(VLEN) + 1
) (
  input  logic [2:0]     sew_code,
  input  logic [2:0]     lmul_code,
  output logic [VLW-1:0] vlmax
);
  logic [VLW-1:0] per_reg;

  always_comb begin
    per_reg = VLW'(VLEN) >> ({1'b0, sew_code} + 4'd3);
    if (lmul_code[2]) begin
      vlmax = per_reg >> frac_shift(lmul_code);
    end else begin
      vlmax = per_reg << lmul_code[1:0];
    end
  end
endmodule

// File: rtl/vtype_cfg_validator.sv
module vtype_cfg_validator
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            altfmt_en,
  input  logic [XLEN-1:0] req_vtype,
  input  logic [XLEN-1:0] req_avl,
  output logic [XLEN-1:0] vtype_o,
  output logic [XLEN-1:0] vl_o
);
  localparam int unsigned VLW = $clog2(VLEN) + 1;
  localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  logic            is_legal;
  logic [VLW-1:0]  vlmax;
  logic [XLEN-1:0] vlmax_x;
  logic [XLEN-1:0] next_vl;

  vtype_field_check #(.XLEN(XLEN), .ELEN(ELEN)) chk_i (
    .top_bit   (req_vtype[XLEN-1]),
    .rsv_bits  (req_vtype[XLEN-2:RSV_LSB]),
    .alt_bit   (req_vtype[ALT_BIT]),
    .alt_enable(altfmt_en),
    .sew_code  (req_vtype[SEW_LSB +: 3]),
    .lmul_code (req_vtype[LMUL_LSB +: 3]),
    .legal     (is_legal)
  );

  vtype_vlmax_calc #(.VLEN(VLEN)) vlmax_i (
    .sew_code (req_vtype[SEW_LSB +: 3]),
    .lmul_code(req_vtype[LMUL_LSB +: 3]),
    .vlmax    (vlmax)
  );

  always_comb begin
    vlmax_x = XLEN'(vlmax);
    next_vl = (req_avl < vlmax_x) ? req_avl : vlmax_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_o <= ILL_WORD;
      vl_o    <= '0;
    end else if (req_valid) begin
      if (is_legal) begin
        vtype_o <= req_vtype;
        vl_o    <= next_vl;
      end else begin
        vtype_o <= ILL_WORD;
        vl_o    <= '0;
      end
    end
  end
endmodule

// File: rtl/vtype_cfg_validator_chk.sv
module vtype_cfg_validator_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            altfmt_en,
  input logic [XLEN-1:0] req_vtype,
  input logic [XLEN-1:0] req_avl,
  input logic [XLEN-1:0] vtype_o,
  input logic [XLEN-1:0] vl_o
);
  // R3
  top_bit_ill_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_vtype[XLEN-1] |=> vtype_o[XLEN-1]);

  // R5
  alt_off_ill_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !altfmt_en && req_vtype[8] |=> vtype_o[XLEN-1]);

  // R7
  wide_sew_ill_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && ((32'd8 << req_vtype[5:3]) > 32'(ELEN)) |=> vtype_o[XLEN-1]);

  // R9
  ill_clears_chk: assert property (@(posedge clk) disable iff (rst)
    vtype_o[XLEN-1] |-> (vl_o == '0) && ($countones(vtype_o) == 1));

  // R10
  vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (vl_o <= $past(req_avl)) && (vl_o <= XLEN'(VLEN)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(vtype_o) && $stable(vl_o));
endmodule

bind vtype_cfg_validator vtype_cfg_validator_chk #(
  .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)
) chk_bind_i (.*);

// File: tb/vtype_cfg_validator_tb_top.sv
module vtype_cfg_validator_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned VLEN = 128;
  localparam int unsigned ELEN = 64;
  localparam logic [XLEN-1:0] ILL = {1'b1, {(XLEN-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic altfmt_en = 1'b0;
  logic [XLEN-1:0] req_vtype = '0;
  logic [XLEN-1:0] req_avl = '0;
  logic [XLEN-1:0] vtype_o;
  logic [XLEN-1:0] vl_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vtype_cfg_validator #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .altfmt_en(altfmt_en),
    .req_vtype(req_vtype), .req_avl(req_avl), .vtype_o(vtype_o), .vl_o(vl_o)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h vtype_in=%h en=%0b",
               req, act, exp, req_vtype, altfmt_en);
    end
  endtask

  function automatic bit model_legal(input logic [XLEN-1:0] w, input logic en);
    int unsigned sew = w[5:3];
    int unsigned lm  = w[2:0];
    int unsigned wb  = 8 << sew;
    if (w[XLEN-1]) return 0;
    if (w[XLEN-2:9] != 0) return 0;
    if (w[8] && !en) return 0;
    if (w[8] && sew > 1) return 0;
    if (wb > ELEN) return 0;
    if (lm == 4) return 0;
    if (lm > 4 && wb > (ELEN >> (8 - lm))) return 0;
    return 1;
  endfunction

  function automatic int unsigned model_vlmax(input logic [XLEN-1:0] w);
    int unsigned base = VLEN / (8 << w[5:3]);
    int unsigned lm = w[2:0];
    if (lm < 4) return base << lm;
    return base >> (8 - lm);
  endfunction

  // drive on a falling edge, let one rising edge register, sample on the next falling edge
  task automatic issue(input logic [XLEN-1:0] w, input logic en,
                       input logic [XLEN-1:0] avl);
    @(negedge clk);
    req_vtype = w; altfmt_en = en; req_avl = avl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [XLEN-1:0] w,
                               input logic en, input logic [XLEN-1:0] avl);
    int unsigned vm;
    if (model_legal(w, en)) begin
      vm = model_vlmax(w);
      check({req, " R2 vtype"}, vtype_o, w);
      check({req, " R10 vl"}, vl_o, (avl < vm) ? avl : XLEN'(vm));
    end else begin
      check({req, " R9 vtype"}, vtype_o, ILL);
      check({req, " R9 vl"}, vl_o, '0);
    end
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] w;
    int unsigned vm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 vtype reset", vtype_o, ILL);
    check("R1 vl reset", vl_o, '0);

    // full sweep of the low nine bits, extension off and on (R5 R6 R7 R8 R10)
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 512; b++) begin
        w = XLEN'(b);
        vm = model_vlmax(w);
        for (int k = 0; k < 3; k++) begin
          logic [XLEN-1:0] avl;
          avl = (k == 0) ? XLEN'(vm) - 1 : (k == 1) ? XLEN'(vm) : XLEN'(vm) + 1;
          issue(w, e[0], avl);
          expect_result("sweep R5 R6 R7 R8", w, e[0], avl);
        end
      end
    end

    // R6 targeted: alternate format with 16-bit elements legal, 32-bit illegal
    issue(32'h0000_0108, 1'b1, 32'd5);
    check("R6 alt sew16 vtype", vtype_o, 32'h0000_0108);
    check("R6 alt sew16 vl", vl_o, 32'd5);
    issue(32'h0000_0110, 1'b1, 32'd5);
    check("R6 alt sew32 illegal", vtype_o, ILL);

    // R4 walking reserved bits with extension on, on a legal base
    for (int p = 9; p <= XLEN - 2; p++) begin
      w = 32'h0000_00C0 | (XLEN'(1) << p);
      issue(w, 1'b1, 32'd3);
      check("R4 reserved bit", vtype_o, ILL);
      check("R4 reserved vl", vl_o, '0);
    end

    // R3 top bit on an otherwise legal word
    issue(32'h0000_0000, 1'b1, 32'd7);
    check("R2 legal base", vtype_o, 32'h0);
    issue(ILL | 32'h0000_0001, 1'b1, 32'd7);
    check("R3 top bit vtype", vtype_o, ILL);
    check("R3 top bit vl", vl_o, '0);

    // R10 large request clamps to VLMAX (SEW 8, LMUL 8 gives VLEN)
    issue(32'h0000_0003, 1'b0, 32'hFFFF_FFFF);
    check("R10 clamp", vl_o, XLEN'(VLEN));
    issue(32'h0000_0003, 1'b0, 32'd0);
    check("R10 zero avl", vl_o, 32'd0);

    // R11 inputs change while req_valid low
    issue(32'h0000_0009, 1'b0, 32'd6);
    @(negedge clk);
    req_vtype = ILL; req_avl = 32'd1;
    @(negedge clk);
    req_vtype = 32'h0000_0002;
    @(negedge clk);
    check("R11 hold vtype", vtype_o, 32'h0000_0009);
    check("R11 hold vl", vl_o, 32'd6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule